// File: doc/BRIEF.md
# Fractional Reference Rate Divider

This block produces the nominal tick of a real-time counter from a reference that runs faster than the tick. It watches one selected reference signal, finds its rising edges after synchronising it into the local clock, and uses an accumulator to emit N one-cycle ticks for every D reference edges. The ratio need not be a whole number, so a reference of any frequency can be brought down to the wanted tick rate. The ticks are spread as evenly as the accumulator allows.

Software writes two registers. The ratio register holds both terms of the ratio, each stored as its value minus one. The source register picks the reference: the dedicated slow clock input, or one of three bits of an external free-running counter. It also has a bypass bit that turns every reference edge into a tick. Writing either register restarts the accumulator, so a new setting always starts from a known phase. The power-on setting divides by 15625/1024. That suits a 31250 Hz reference, which is what the counter bit 11 option gives.

Top module: `ref_rate_divider`

## Requirements
- R1: While `rst` is high, `tick` is low. Reset puts the ratio register at N-1 = 1023 and D-1 = 15624 (word 0x3D0803FF), selects the slow clock input with bypass off, and clears the accumulator. With that setting, 20 slow clock edges give exactly 1 tick.
- R2: A write with `wr_addr` = 0 loads the ratio register: D-1 from `wr_data[31:16]` and N-1 from `wr_data[15:0]`. With N < D, E reference edges that follow a write give floor(E*N/D) ticks.
- R3: When the stored N-1 is greater than or equal to the stored D-1, every reference edge gives one tick.
- R4: A write with `wr_addr` = 1 loads the source register. Field `wr_data[5:4]` picks the reference: 0 is `slow_ref`, and k = 1..3 is `sys_count[9+k]`, so 2 is counter bit 11. All other bits, except bit 0, have no effect.
- R5: When bit 0 of the source register (bypass) is set, every reference edge gives one tick, whatever the ratio.
- R6: Only rising edges of the selected reference count. Inputs that are not selected have no effect on `tick`.
- R7: Any register write clears the accumulator to zero, so the fractional remainder left by earlier edges is dropped.
- R8: `tick` is high for exactly one cycle per tick and never in two consecutive cycles. It rises only in the cycle after a detected edge.
- R9: The accumulator always stays below D.
- R10: The selected reference is first sampled high at clock edge k. It passes a two-flop synchroniser and an edge detector. The tick it causes is high from edge k+2 to edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = ratio register, 1 = source register |
| wr_data | input | 32 | Register write data |
| slow_ref | input | 1 | Dedicated slow reference clock |
| sys_count | input | CNT_W (16) | Free-running system counter |
| tick | output | 1 | One-cycle output tick |

## Verification
The assertions check on every cycle that the accumulator stays below D and that a write clears it. They also check that a tick follows only a detected edge, that ticks and edges never come in two consecutive cycles, and that bypass or a full-rate ratio turns each edge into a tick. The bench scenarios are the only check on long-run tick counts against floor(E*N/D), the register field layout, the choice of reference source, the exact three-cycle latency, and that unselected inputs are ignored.

// File: rtl/rrd_pkg.sv
package rrd_pkg;

    localparam int FIELD_W = 16;
    localparam int DATA_W  = 32;
    localparam int ACC_W   = FIELD_W + 2;

    typedef struct packed {
        logic [FIELD_W-1:0] d_m1;
        logic [FIELD_W-1:0] n_m1;
    } ratio_cfg_t;

    typedef enum logic [1:0] {
        SRC_SLOW  = 2'd0,
        SRC_CNT_1 = 2'd1,
        SRC_CNT_2 = 2'd2,
        SRC_CNT_3 = 2'd3
    } ref_src_e;

    typedef struct packed {
        ref_src_e src;
        logic     bypass;
    } ref_cfg_t;

    localparam ratio_cfg_t RATIO_RST = '{d_m1: 16'd15624, n_m1: 16'd1023};
    localparam ref_cfg_t   REF_RST   = '{src: SRC_SLOW, bypass: 1'b0};

    function automatic ratio_cfg_t unpack_ratio(input logic [DATA_W-1:0] w);
        ratio_cfg_t r;
        r.d_m1 = w[31:16];
        r.n_m1 = w[15:0];
        return r;
    endfunction

    function automatic ref_cfg_t unpack_ref(input logic [DATA_W-1:0] w);
        ref_cfg_t r;
        r.src    = ref_src_e'(w[5:4]);
        r.bypass = w[0];
        return r;
    endfunction

endpackage

// File: rtl/rrd_cfg_regs.sv
module rrd_cfg_regs
    import rrd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output ratio_cfg_t        ratio,
    output ref_cfg_t          refc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ratio <= RATIO_RST;
            refc  <= REF_RST;
        end else if (wr_en) begin
            if (wr_addr) refc  <= unpack_ref(wr_data);
            else         ratio <= unpack_ratio(wr_data);
        end
    end

endmodule

// File: rtl/rrd_ref_select.sv
module rrd_ref_select
    import rrd_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int BASE_BIT    = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  ref_cfg_t         refc,
    input  logic             slow_ref,
    input  logic [CNT_W-1:0] sys_count,
    output logic             edge_o
);

    localparam int N_SRC = 4;

    logic [N_SRC-1:0]       cand;
    logic                   sel_ref;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    assign cand[0] = slow_ref;
    for (genvar k = 1; k < N_SRC; k++) begin : g_cnt_tap
        assign cand[k] = sys_count[BASE_BIT + k];
    end

    assign sel_ref = cand[refc.src];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], sel_ref};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign edge_o = sync_q[SYNC_STAGES-1] & ~prev_q;

    // R8: an edge pulse never lasts two cycles
    p_edge_gap_r8: assert property (@(posedge clk) disable iff (rst)
        edge_o |=> !edge_o);

endmodule

// File: rtl/rrd_accum.sv
module rrd_accum
    import rrd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       edge_i,
    input  ratio_cfg_t ratio,
    input  logic       bypass,
    output logic       tick
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] n_step;
    logic [ACC_W-1:0] d_mod;
    logic [ACC_W-1:0] sum;
    logic             wrap;
    logic             full_rate;

    always_comb begin
        n_step    = {2'b00, ratio.n_m1} + ACC_W'(1);
        d_mod     = {2'b00, ratio.d_m1} + ACC_W'(1);
        sum       = acc_q + n_step;
        wrap      = (sum >= d_mod);
        full_rate = (ratio.n_m1 >= ratio.d_m1);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_q <= '0;
            tick  <= 1'b0;
        end else if (edge_i) begin
            if (bypass || full_rate) begin
                acc_q <= '0;
                tick  <= 1'b1;
            end else if (wrap) begin
                acc_q <= sum - d_mod;
                tick  <= 1'b1;
            end else begin
                acc_q <= sum;
                tick  <= 1'b0;
            end
        end else begin
            tick <= 1'b0;
        end
    end

    // R9: remainder stays below the modulus
    p_acc_bound_r9: assert property (@(posedge clk) disable iff (rst)
        acc_q < d_mod);

    // R7: a register write zeroes the accumulator
    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc_q == '0) && !tick);

    // R8: a tick only follows a detected edge
    p_tick_cause_r8: assert property (@(posedge clk) disable iff (rst)
        tick |-> $past(edge_i));

    // R5: bypass turns every edge into a tick
    p_bypass_r5: assert property (@(posedge clk) disable iff (rst)
        (edge_i && bypass && !clr) |=> tick);

    // R3: ratio at or above one ticks on every edge
    p_full_rate_r3: assert property (@(posedge clk) disable iff (rst)
        (edge_i && !clr && (ratio.n_m1 >= ratio.d_m1)) |=> tick);

endmodule

// File: rtl/ref_rate_divider.sv
module ref_rate_divider
    import rrd_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int BASE_BIT    = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              slow_ref,
    input  logic [CNT_W-1:0]  sys_count,
    output logic              tick
);

    ratio_cfg_t ratio;
    ref_cfg_t   refc;
    logic       ref_edge;

    rrd_cfg_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ratio   (ratio),
        .refc    (refc)
    );

    rrd_ref_select #(
        .CNT_W       (CNT_W),
        .BASE_BIT    (BASE_BIT),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sel (
        .clk       (clk),
        .rst       (rst),
        .refc      (refc),
        .slow_ref  (slow_ref),
        .sys_count (sys_count),
        .edge_o    (ref_edge)
    );

    rrd_accum u_acc (
        .clk    (clk),
        .rst    (rst),
        .clr    (wr_en),
        .edge_i (ref_edge),
        .ratio  (ratio),
        .bypass (refc.bypass),
        .tick   (tick)
    );

    // R1: tick is quiet through reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> !tick);

endmodule

// File: tb/ref_rate_divider_test.sv
module ref_rate_divider_test;

    localparam int CLK_P = 10;
    localparam int CNT_W = 16;
    localparam int BASE  = 9;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic             wr_addr = 1'b0;
    logic [31:0]      wr_data = '0;
    logic             slow_ref = 1'b0;
    logic [CNT_W-1:0] sys_count = '0;
    logic             tick;

    int checks = 0;
    int errors = 0;
    int cur_src = 0;
    bit done = 0;

    ref_rate_divider #(.CNT_W(CNT_W), .BASE_BIT(BASE)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .slow_ref(slow_ref), .sys_count(sys_count),
        .tick(tick)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic int exp_ticks(int n1, int d1, int e, bit byp);
        longint p;
        if (byp || n1 >= d1) return e;
        p = longint'(e) * longint'(n1);
        return int'(p / longint'(d1));
    endfunction

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic quiet();
        slow_ref  = 1'b0;
        sys_count = '0;
    endtask

    task automatic drive(input logic lvl);
        logic [CNT_W-1:0] cv;
        cv = CNT_W'($urandom);
        if (cur_src == 0) begin
            slow_ref  = lvl;
            sys_count = cv;
        end else begin
            cv[BASE + cur_src] = lvl;
            sys_count = cv;
            slow_ref  = 1'($urandom % 2);
        end
    endtask

    task automatic reg_write(input logic addr, input logic [31:0] data);
        @(negedge clk);
        quiet();
        repeat (4) @(negedge clk);
        wr_en = 1'b1; wr_addr = addr; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
        if (addr) cur_src = int'(data[5:4]);
    endtask

    task automatic set_ratio(input int n1, input int d1);
        reg_write(1'b0, {16'(d1 - 1), 16'(n1 - 1)});
    endtask

    task automatic run_edges(input int e, output int ticks);
        ticks = 0;
        for (int i = 0; i < e; i++) begin
            for (int c = 0; c < 6; c++) begin
                @(negedge clk);
                if (tick) ticks++;
                drive(c < 3);
            end
        end
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            if (tick) ticks++;
            drive(1'b0);
        end
    endtask

    initial begin
        int t, hi, n1, d1, e, s;
        int lat[4];
        void'($urandom(32'h5EED));

        // R1: reset state
        hi = 0;
        repeat (4) begin @(negedge clk); if (tick) hi++; end
        check_eq("R1 tick low in reset", hi, 0);
        rst = 1'b0;
        run_edges(20, t);
        check_eq("R1 default ratio 1024/15625", t, exp_ticks(1024, 15625, 20, 0));

        // R2: directed ratio 2/4
        set_ratio(2, 4);
        run_edges(10, t);
        check_eq("R2 ratio 2/4", t, 5);

        // R2: wide field, exact half
        reg_write(1'b0, {16'hFFFF, 16'h7FFF});
        run_edges(10, t);
        check_eq("R2 ratio 32768/65536", t, 5);

        // R3: N above D and both fields full
        set_ratio(7, 3);
        run_edges(9, t);
        check_eq("R3 N above D", t, 9);
        reg_write(1'b0, 32'hFFFF_FFFF);
        run_edges(8, t);
        check_eq("R3 both fields max", t, 8);

        // R5: bypass overrides a slow ratio
        set_ratio(1, 50);
        reg_write(1'b1, 32'h0000_0001);
        run_edges(7, t);
        check_eq("R5 bypass every edge", t, 7);

        // R10: latency three clocks with bypass on
        @(negedge clk); quiet(); repeat (4) @(negedge clk);
        drive(1'b1);
        for (int i = 0; i < 4; i++) begin @(negedge clk); lat[i] = int'(tick); end
        check_eq("R10 latency cycle 1", lat[0], 0);
        check_eq("R10 latency cycle 2", lat[1], 0);
        check_eq("R10 latency cycle 3", lat[2], 1);
        check_eq("R8 single cycle tick", lat[3], 0);
        drive(1'b0); repeat (4) @(negedge clk);

        // R6: unselected inputs toggle while counter bit 11 held low
        reg_write(1'b1, 32'h0000_0021);
        hi = 0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (tick) hi++;
            drive(1'b0);
        end
        check_eq("R6 unselected inputs ignored", hi, 0);

        // R4: counter bit 11 selected, recommended source value
        reg_write(1'b1, 32'h0000_0020);
        set_ratio(3, 5);
        run_edges(12, t);
        check_eq("R4 counter bit 11 source", t, exp_ticks(3, 5, 12, 0));

        // R4: stray bits in the source word are ignored
        reg_write(1'b1, 32'hFFFF_FFCE);
        set_ratio(1, 3);
        run_edges(9, t);
        check_eq("R4 stray source bits ignored", t, 3);

        // R7: write drops the remainder
        set_ratio(3, 4);
        run_edges(1, t);
        check_eq("R7 first edge below modulus", t, 0);
        set_ratio(3, 4);
        run_edges(1, t);
        check_eq("R7 remainder cleared by write", t, 0);
        run_edges(1, t);
        check_eq("R7 remainder kept without write", t, 1);

        // R2 R4: random ratios and sources
        for (int it = 0; it < 8; it++) begin
            d1 = 2 + int'($urandom % 39);
            n1 = 1 + int'($urandom % (d1 - 1));
            s  = int'($urandom % 4);
            e  = 10 + int'($urandom % 40);
            reg_write(1'b1, {26'h0, 2'(s), 4'h0});
            set_ratio(n1, d1);
            run_edges(e, t);
            check_eq($sformatf("R2 random %0d/%0d src %0d", n1, d1, s),
                     t, exp_ticks(n1, d1, e, 0));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule